// File: doc/BRIEF.md
# Stop-Mode Wake-Up Recovery Controller

This block governs how a small microcontroller leaves its low-power stop state. When the core raises a stop request, the block drops a clock-enable output, which gates the core clock, and then watches one wake source. A small configuration register selects that source. It can be one pin of a 4-bit wake port, the top pin of an 8-bit port, or the NOR of the lower half or of all of that 8-bit port. The register also sets the level that counts as active and chooses between a fast wake and a delayed wake.

In fast mode the selected source must hold its active level for a qualifying number of consecutive cycles before the clock comes back. In delayed mode a single active sample starts a reset-length delay, and the clock restarts when it expires. Every port input passes through a two-flop synchronizer before it is selected. A warm-start flag is set on stop entry and can be read back, so that software can tell a wake-up from a cold start. A watchdog reset input or the power-on reset abandons stop mode at once and clears the flag.

Top module: `stop_wake_ctrl`

## Requirements
- R1: While reset is held and after it is released, `clk_en_o` is 1, `wake_pulse_o` is 0 and `reg_rdata_o` reads 6'h10: source code 000, active level low, delayed wake selected, warm flag 0.
- R2: The register layout is: bits [2:0] hold the source code, bit 3 selects the active level (1 = high), bit 4 selects delayed wake, and bit 5 holds the read-only warm flag. Writes use `reg_wdata_i[4:0]` only.
- R3: A `stop_req_i` sampled while running drives `clk_en_o` low from the next cycle and sets the warm flag.
- R4: The source codes are 000 (none, so only a reset can leave stop), 001/010/011/100 (wake port bit 0/1/2/3), 101 (8-bit port bit 7), 110 (NOR of 8-bit port bits 3:0) and 111 (NOR of all eight bits).
- R5: While `analog_mode_i` is 1, codes 010, 011 and 100 never wake the block.
- R6: The selected source is active when it equals the active-level bit.
- R7: In fast mode, a wake requires 5 consecutive cycles of the synchronized source being active. From a port change to `clk_en_o` high takes 7 rising edges. A run of 4 active cycles does not wake the block.
- R8: In delayed mode, the first active synchronized sample starts a delay of DLY_CYC cycles. `clk_en_o` rises DLY_CYC+3 edges after the port change (67 by default).
- R9: `wake_pulse_o` is high for exactly one cycle, in the first cycle that `clk_en_o` is high again.
- R10: `stop_req_i` is ignored while stopped or while the delay runs. The wake completes on time and the clock stays enabled afterwards.
- R11: `wdt_rst_i` returns the block to running at the next edge and clears the warm flag. The configuration bits are kept.
- R12: The warm flag reads 1 while stopped and remains 1 after a wake caused by the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, not gated during stop |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| wdt_rst_i | input | 1 | Watchdog reset request, synchronous |
| stop_req_i | input | 1 | Stop-entry request from the core |
| analog_mode_i | input | 1 | Masks wake-port bits 1 to 3 as wake sources when high |
| port2_i | input | 8 | 8-bit wake port |
| port3_i | input | 4 | 4-bit wake port |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 5 | Register write data |
| reg_rdata_o | output | 6 | Register read data including warm flag |
| clk_en_o | output | 1 | Core clock enable |
| wake_pulse_o | output | 1 | One-cycle wake indication |

## Verification
The hardest case to reach from the ports is a fast-mode source that is active for just under the qualifying time. The count only starts after two synchronizer stages, so the glitch has to be timed against the edges. The bench holds the wake pin active for exactly four rising edges and checks that no wake follows. It then holds the pin for good and checks the exact latency. A stop request injected in the middle of a 64-cycle delay is the second case that is hard to reach: the bench counts edges from the port change and fires the request partway through the delay.

// File: rtl/swr_pkg.sv
package swr_pkg;
  localparam int CODE_W   = 3;
  localparam int WR_W     = 5;
  localparam int RD_W     = 6;
  localparam int FLAG_BIT = 5;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_STOP  = 2'd1,
    ST_DELAY = 2'd2
  } swr_state_e;

  typedef struct packed {
    logic              full_delay;
    logic              active_high;
    logic [CODE_W-1:0] code;
  } swr_cfg_t;

  localparam swr_cfg_t CFG_RST = '{full_delay: 1'b1, active_high: 1'b0, code: '0};

  localparam logic [CODE_W-1:0] SRC_NONE  = 3'd0;
  localparam logic [CODE_W-1:0] SRC_P3B0  = 3'd1;
  localparam logic [CODE_W-1:0] SRC_P3B1  = 3'd2;
  localparam logic [CODE_W-1:0] SRC_P3B2  = 3'd3;
  localparam logic [CODE_W-1:0] SRC_P3B3  = 3'd4;
  localparam logic [CODE_W-1:0] SRC_P2B7  = 3'd5;
  localparam logic [CODE_W-1:0] SRC_P2LO  = 3'd6;
  localparam logic [CODE_W-1:0] SRC_P2ALL = 3'd7;
endpackage

// File: rtl/swr_sync.sv
module swr_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      logic s1_q, s2_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1_q <= 1'b0;
          s2_q <= 1'b0;
        end else begin
          s1_q <= d_i[gi];
          s2_q <= s1_q;
        end
      end
      assign q_o[gi] = s2_q;
    end
  endgenerate
endmodule

// File: rtl/swr_src_sel.sv
module swr_src_sel
  import swr_pkg::*;
#(
  parameter int P2_W = 8,
  parameter int P3_W = 4
) (
  input  logic [P2_W-1:0]   p2_i,
  input  logic [P3_W-1:0]   p3_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              active_high_i,
  input  logic              analog_i,
  output logic              active_o
);
  localparam int LO_W = P2_W / 2;

  logic raw_lvl;
  logic masked;
  logic enabled;

  always_comb begin
    unique case (code_i)
      SRC_P3B0:  raw_lvl = p3_i[0];
      SRC_P3B1:  raw_lvl = p3_i[1];
      SRC_P3B2:  raw_lvl = p3_i[2];
      SRC_P3B3:  raw_lvl = p3_i[3];
      SRC_P2B7:  raw_lvl = p2_i[P2_W-1];
      SRC_P2LO:  raw_lvl = ~|p2_i[LO_W-1:0];
      SRC_P2ALL: raw_lvl = ~|p2_i;
      default:   raw_lvl = 1'b0;
    endcase
    masked   = analog_i && ((code_i == SRC_P3B1) || (code_i == SRC_P3B2) || (code_i == SRC_P3B3));
    enabled  = (code_i != SRC_NONE) && !masked;
    active_o = enabled && (raw_lvl == active_high_i);
  end
endmodule

// File: rtl/swr_cfg.sv
module swr_cfg
  import swr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [WR_W-1:0] wdata_i,
  output swr_cfg_t        cfg_o
);
  swr_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we_i) cfg_d = swr_cfg_t'(wdata_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RST;
    else        cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/swr_seq.sv
module swr_seq
  import swr_pkg::*;
#(
  parameter int QUAL_CYC = 5,
  parameter int DLY_CYC  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req_i,
  input  logic       wdt_rst_i,
  input  logic       src_active_i,
  input  logic       full_delay_i,
  output swr_state_e state_o,
  output logic       clk_en_o,
  output logic       wake_pulse_o,
  output logic       warm_o
);
  localparam int MAX_CYC = (QUAL_CYC > DLY_CYC) ? QUAL_CYC : DLY_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] QUAL_LAST = CNT_W'(QUAL_CYC - 1);
  localparam logic [CNT_W-1:0] DLY_LAST  = CNT_W'(DLY_CYC - 1);

  swr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             warm_q, warm_d;
  logic             pulse_q, pulse_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    warm_d  = warm_q;
    pulse_d = 1'b0;
    if (wdt_rst_i) begin
      state_d = ST_RUN;
      cnt_d   = '0;
      warm_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (stop_req_i) begin
            state_d = ST_STOP;
            cnt_d   = '0;
            warm_d  = 1'b1;
          end
        end
        ST_STOP: begin
          if (src_active_i) begin
            if (full_delay_i) begin
              state_d = ST_DELAY;
              cnt_d   = '0;
            end else if (cnt_q == QUAL_LAST) begin
              state_d = ST_RUN;
              cnt_d   = '0;
              pulse_d = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else begin
            cnt_d = '0;
          end
        end
        ST_DELAY: begin
          if (cnt_q == DLY_LAST) begin
            state_d = ST_RUN;
            cnt_d   = '0;
            pulse_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      warm_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      warm_q  <= warm_d;
      pulse_q <= pulse_d;
    end
  end

  assign state_o      = state_q;
  assign clk_en_o     = (state_q == ST_RUN);
  assign wake_pulse_o = pulse_q;
  assign warm_o       = warm_q;
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import swr_pkg::*;
#(
  parameter int P2_W     = 8,
  parameter int P3_W     = 4,
  parameter int QUAL_CYC = 5,
  parameter int DLY_CYC  = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wdt_rst_i,
  input  logic            stop_req_i,
  input  logic            analog_mode_i,
  input  logic [P2_W-1:0] port2_i,
  input  logic [P3_W-1:0] port3_i,
  input  logic            reg_we_i,
  input  logic [WR_W-1:0] reg_wdata_i,
  output logic [RD_W-1:0] reg_rdata_o,
  output logic            clk_en_o,
  output logic            wake_pulse_o
);
  localparam int SYNC_W = P2_W + P3_W;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  logic [SYNC_W-1:0] ports_sync;
  swr_sync #(.W(SYNC_W)) sync_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   ({port2_i, port3_i}),
    .q_o   (ports_sync)
  );

  swr_cfg_t cfg_q;
  swr_cfg cfg_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .cfg_o   (cfg_q)
  );

  logic src_active;
  swr_src_sel #(.P2_W(P2_W), .P3_W(P3_W)) sel_i (
    .p2_i          (ports_sync[SYNC_W-1:P3_W]),
    .p3_i          (ports_sync[P3_W-1:0]),
    .code_i        (cfg_q.code),
    .active_high_i (cfg_q.active_high),
    .analog_i      (analog_mode_i),
    .active_o      (src_active)
  );

  swr_state_e seq_state;
  logic       warm_flag;
  swr_seq #(.QUAL_CYC(QUAL_CYC), .DLY_CYC(DLY_CYC)) seq_i (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .stop_req_i   (stop_req_i),
    .wdt_rst_i    (wdt_rst_i),
    .src_active_i (src_active),
    .full_delay_i (cfg_q.full_delay),
    .state_o      (seq_state),
    .clk_en_o     (clk_en_o),
    .wake_pulse_o (wake_pulse_o),
    .warm_o       (warm_flag)
  );

  assign reg_rdata_o = {warm_flag, cfg_q};
endmodule

// File: rtl/swr_chk.sv
module swr_chk
  import swr_pkg::*;
#(
  parameter int QUAL_CYC = 5,
  parameter int DLY_CYC  = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wdt_rst_i,
  input logic            stop_req_i,
  input logic            analog_mode_i,
  input logic [RD_W-1:0] reg_rdata_o,
  input logic            clk_en_o,
  input logic            wake_pulse_o,
  input swr_state_e      state,
  input logic            src_active
);
  localparam int DW = $clog2(DLY_CYC + 1) + 1;

  logic [7:0]    act_run;
  logic [DW-1:0] dly_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_run <= '0;
      dly_run <= '0;
    end else begin
      if (state == ST_STOP && src_active) act_run <= (act_run == 8'hFF) ? act_run : act_run + 1'b1;
      else                                act_run <= '0;
      if (state == ST_DELAY) dly_run <= (&dly_run) ? dly_run : dly_run + 1'b1;
      else                   dly_run <= '0;
    end
  end

  p_stop_gates_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && stop_req_i && !wdt_rst_i) |=> (!clk_en_o && reg_rdata_o[FLAG_BIT]));

  p_code_none_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP && reg_rdata_o[2:0] == SRC_NONE && !wdt_rst_i) |=> state == ST_STOP);

  p_analog_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP && analog_mode_i && !wdt_rst_i &&
     (reg_rdata_o[2:0] == SRC_P3B1 || reg_rdata_o[2:0] == SRC_P3B2 || reg_rdata_o[2:0] == SRC_P3B3))
    |=> state == ST_STOP);

  p_fast_qual_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP && !wdt_rst_i && act_run < 8'(QUAL_CYC - 1)) |=> state != ST_RUN);

  p_delay_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DELAY && !wdt_rst_i && dly_run < DW'(DLY_CYC - 1)) |=> state == ST_DELAY);

  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse_o |=> !wake_pulse_o);

  p_pulse_at_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse_o |-> (clk_en_o && $past(!clk_en_o)));

  p_delay_no_restop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DELAY && !wdt_rst_i) |=> state != ST_STOP);

  p_wdt_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_i |=> (clk_en_o && !reg_rdata_o[FLAG_BIT]));

  p_warm_in_stop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RUN) |-> reg_rdata_o[FLAG_BIT]);
endmodule

bind stop_wake_ctrl swr_chk #(.QUAL_CYC(QUAL_CYC), .DLY_CYC(DLY_CYC)) chk_i (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .wdt_rst_i     (wdt_rst_i),
  .stop_req_i    (stop_req_i),
  .analog_mode_i (analog_mode_i),
  .reg_rdata_o   (reg_rdata_o),
  .clk_en_o      (clk_en_o),
  .wake_pulse_o  (wake_pulse_o),
  .state         (seq_state),
  .src_active    (src_active)
);

// File: tb/stop_wake_ctrl_tb_top.sv
module stop_wake_ctrl_tb_top;
  localparam int DLY     = 64;
  localparam int FAST    = 7;
  localparam int MAX_WAIT = 100;
  localparam int NVEC    = 14;

  logic       clk;
  logic       rst_n;
  logic       wdt_rst_i;
  logic       stop_req_i;
  logic       analog_mode_i;
  logic [7:0] port2_i;
  logic [3:0] port3_i;
  logic       reg_we_i;
  logic [4:0] reg_wdata_i;
  logic [5:0] reg_rdata_o;
  logic       clk_en_o;
  logic       wake_pulse_o;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  stop_wake_ctrl #(.DLY_CYC(DLY)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wdt_rst_i     (wdt_rst_i),
    .stop_req_i    (stop_req_i),
    .analog_mode_i (analog_mode_i),
    .port2_i       (port2_i),
    .port3_i       (port3_i),
    .reg_we_i      (reg_we_i),
    .reg_wdata_i   (reg_wdata_i),
    .reg_rdata_o   (reg_rdata_o),
    .clk_en_o      (clk_en_o),
    .wake_pulse_o  (wake_pulse_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [2:0] code;
    logic       pol;
    logic       dly;
    logic       ana;
    logic [7:0] idle2;
    logic [3:0] idle3;
    logic [7:0] act2;
    logic [3:0] act3;
    logic [7:0] lat;
  } vec_t;

  // lat 0 = no wake expected
  localparam vec_t VECS [NVEC] = '{
    '{3'd1, 1'b1, 1'b0, 1'b0, 8'h00, 4'h0, 8'h00, 4'h1, 8'd7},
    '{3'd1, 1'b0, 1'b0, 1'b0, 8'h00, 4'hF, 8'h00, 4'hE, 8'd7},
    '{3'd2, 1'b1, 1'b0, 1'b0, 8'h00, 4'h0, 8'h00, 4'h2, 8'd7},
    '{3'd2, 1'b1, 1'b0, 1'b1, 8'h00, 4'h0, 8'h00, 4'h2, 8'd0},
    '{3'd3, 1'b1, 1'b0, 1'b0, 8'h00, 4'h0, 8'h00, 4'h4, 8'd7},
    '{3'd4, 1'b0, 1'b0, 1'b1, 8'h00, 4'hF, 8'h00, 4'h7, 8'd0},
    '{3'd4, 1'b0, 1'b0, 1'b0, 8'h00, 4'hF, 8'h00, 4'h7, 8'd7},
    '{3'd5, 1'b1, 1'b0, 1'b0, 8'h00, 4'h0, 8'h80, 4'h0, 8'd7},
    '{3'd6, 1'b1, 1'b0, 1'b0, 8'hFF, 4'h0, 8'hF0, 4'h0, 8'd7},
    '{3'd6, 1'b1, 1'b0, 1'b0, 8'hFF, 4'h0, 8'hF1, 4'h0, 8'd0},
    '{3'd7, 1'b0, 1'b0, 1'b0, 8'h00, 4'h0, 8'h40, 4'h0, 8'd7},
    '{3'd0, 1'b1, 1'b0, 1'b0, 8'h00, 4'h0, 8'hFF, 4'hF, 8'd0},
    '{3'd1, 1'b1, 1'b1, 1'b0, 8'h00, 4'h0, 8'h00, 4'h1, 8'd67},
    '{3'd5, 1'b1, 1'b0, 1'b0, 8'h00, 4'h0, 8'h7F, 4'h0, 8'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [4:0] val);
    reg_we_i    = 1'b1;
    reg_wdata_i = val;
    tick(1);
    reg_we_i    = 1'b0;
  endtask

  task automatic do_stop();
    stop_req_i = 1'b1;
    tick(1);
    stop_req_i = 1'b0;
  endtask

  task automatic pulse_wdt();
    wdt_rst_i = 1'b1;
    tick(1);
    wdt_rst_i = 1'b0;
  endtask

  // counts edges from now until clk_en_o rises; 0 if never
  task automatic measure(output int lat, output int pulse_seen, input int inject_at);
    lat = 0;
    pulse_seen = 0;
    for (int k = 1; k <= MAX_WAIT; k++) begin
      if (k == inject_at) stop_req_i = 1'b1;
      tick(1);
      stop_req_i = 1'b0;
      if (clk_en_o && lat == 0) begin
        lat = k;
        pulse_seen = int'(wake_pulse_o);
      end
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int lat, pls;
    rst_n = 1'b0; wdt_rst_i = 0; stop_req_i = 0; analog_mode_i = 0;
    port2_i = 0; port3_i = 0; reg_we_i = 0; reg_wdata_i = 0;
    tick(3);
    check("R1 clk_en in reset", int'(clk_en_o), 1);
    rst_n = 1'b1;
    tick(4);
    check("R1 reset clk_en", int'(clk_en_o), 1);
    check("R1 reset pulse", int'(wake_pulse_o), 0);
    check("R1 reset rdata", int'(reg_rdata_o), 'h10);

    // R2 layout: flag is read-only, writable bits read back
    write_cfg(5'h1F);
    check("R2 readback", int'(reg_rdata_o), 'h1F);
    write_cfg(5'h0A);
    check("R2 readback code/pol", int'(reg_rdata_o), 'h0A);

    // table walk: R4 R5 R6 R7 R8 R9 R12
    for (int v = 0; v < NVEC; v++) begin
      port2_i = VECS[v].idle2;
      port3_i = VECS[v].idle3;
      analog_mode_i = VECS[v].ana;
      write_cfg({VECS[v].dly, VECS[v].pol, VECS[v].code});
      tick(4);
      do_stop();
      check("R3 clk_en low after stop", int'(clk_en_o), 0);
      port2_i = VECS[v].act2;
      port3_i = VECS[v].act3;
      measure(lat, pls, 0);
      if (lat != int'(VECS[v].lat))
        $display("  (vector %0d) R4/R5/R6/R7/R8", v);
      check("R4/R5/R6/R7/R8 wake latency", lat, int'(VECS[v].lat));
      if (VECS[v].lat != 0) begin
        check("R9 pulse with clk_en rise", pls, 1);
        check("R12 warm flag after wake", int'(reg_rdata_o[5]), 1);
      end else begin
        pulse_wdt();
        check("R11 wdt restores clock", int'(clk_en_o), 1);
        check("R11 wdt clears flag", int'(reg_rdata_o[5]), 0);
      end
      port2_i = VECS[v].idle2;
      port3_i = VECS[v].idle3;
      analog_mode_i = 1'b0;
      tick(4);
    end

    // R7 boundary: four active cycles must not wake
    port3_i = 4'h0; port2_i = 8'h00;
    write_cfg(5'b0_1_001);
    tick(4);
    do_stop();
    port3_i = 4'h1;
    tick(4);
    port3_i = 4'h0;
    tick(20);
    check("R7 four-cycle glitch ignored", int'(clk_en_o), 0);
    port3_i = 4'h1;
    measure(lat, pls, 0);
    check("R7 steady source latency", lat, FAST);
    port3_i = 4'h0;
    tick(4);

    // R10: stop request during the delay is ignored
    write_cfg(5'b1_1_001);
    tick(4);
    do_stop();
    do_stop();
    check("R10 repeated stop stays stopped", int'(clk_en_o), 0);
    port3_i = 4'h1;
    measure(lat, pls, 20);
    check("R10 delay unaffected by stop_req", lat, DLY + 3);
    check("R10 clock stays enabled", int'(clk_en_o), 1);
    port3_i = 4'h0;
    tick(4);

    // R11: watchdog aborts stop, keeps config
    write_cfg(5'b1_0_000);
    tick(2);
    do_stop();
    tick(5);
    check("R12 flag while stopped", int'(reg_rdata_o[5]), 1);
    check("R3 still stopped", int'(clk_en_o), 0);
    pulse_wdt();
    check("R11 abort clk_en", int'(clk_en_o), 1);
    check("R11 abort flag", int'(reg_rdata_o[5]), 0);
    check("R11 config kept", int'(reg_rdata_o[4:0]), 'h10);

    // R1: power-on reset in the middle of stop
    write_cfg(5'b0_1_011);
    tick(2);
    do_stop();
    tick(3);
    rst_n = 1'b0;
    #1;
    check("R1 async reset clk_en", int'(clk_en_o), 1);
    check("R1 async reset rdata", int'(reg_rdata_o), 'h10);
    tick(2);
    rst_n = 1'b1;
    tick(4);
    check("R1 after release", int'(reg_rdata_o), 'h10);

    finish_run();
  end
endmodule